// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block picks the message buffer that receives a CAN frame. It acts once the frame has arrived complete and error-free and sits in the hidden receive buffer. The bit-level receiver raises a one-cycle strobe with the frame's identifier, its IDE (extended format) bit and its RTR bit. The filter then compares that identifier in parallel against the identifier programmed into each of the 15 message buffers. Only buffers that are enabled and set to receive take part. Bits that the global mask clears are treated as don't-care. One dedicated buffer ignores the global mask and uses a separate mask of its own, so it can serve as a wide catch-all path.

The lowest-numbered accepting buffer wins. One clock after the strobe, the block gives either a one-cycle copy command or a one-cycle no-match flag. The copy command carries a one-hot buffer select, a binary index and the frame's RTR bit, and it tells the buffer memory to move the hidden frame into the chosen slot. Identifiers are 29 bits wide. A standard 11-bit identifier sits in the top 11 bits, bits 28 down to 18.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, copy_go, no_match, copy_oh, copy_idx and copy_rtr are all zero.
- R2: An extended frame whose identifier equals an enabled receive buffer's extended identifier, under a fully set mask, raises copy_go for exactly the one cycle after the strobe. copy_idx gives that buffer's index and copy_oh has only bit copy_idx set.
- R3: A global mask bit of 0 makes that identifier bit don't-care, so a buffer accepts a group of identifiers. A bit of 1 must match.
- R4: For a standard frame (IDE=0) only identifier bits 28..18 are compared. Bits 17..0 of both the frame and the buffer are ignored.
- R5: A frame matches only buffers whose IDE setting equals the frame's IDE bit.
- R6: Buffers that are disabled, or set to transmit (buf_rx=0), never accept a frame.
- R7: When several buffers accept, the one with the lowest index wins.
- R8: The buffer at index SEP_IDX (default 14) uses sep_mask in place of the global mask. The global mask has no effect on it.
- R9: When no buffer accepts, no_match is 1 for exactly the one cycle after the strobe, and copy_go and copy_oh stay 0.
- R10: copy_rtr equals the frame's RTR bit in the cycle copy_go is 1. It is 0 otherwise.
- R11: Without a strobe in the previous cycle, all outputs are 0. Strobes on consecutive cycles each give their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe: a checked frame is waiting in the hidden buffer |
| frm_id | input | 29 | Frame identifier; standard IDs in bits 28..18 |
| frm_ide | input | 1 | Frame is extended format |
| frm_rtr | input | 1 | Frame is a remote request |
| buf_en | input | 15 | Per-buffer enable |
| buf_rx | input | 15 | Per-buffer direction, 1 = receive |
| buf_ide | input | 15 | Per-buffer identifier format, 1 = extended |
| buf_id_flat | input | 435 | Buffer identifiers, buffer b in bits [29*b+28 : 29*b] |
| glob_mask | input | 29 | Global mask, 1 = compare bit |
| sep_mask | input | 29 | Mask for the dedicated buffer |
| copy_go | output | 1 | Copy command pulse |
| copy_oh | output | 15 | One-hot target buffer |
| copy_idx | output | 4 | Binary target buffer index |
| copy_rtr | output | 1 | RTR bit of the copied frame |
| no_match | output | 1 | Pulse: no buffer accepted the frame |

## Verification
Every result is due exactly one clock after the strobe edge, because one register stage sits between the strobe and the outputs. The driver records the cycle number at which each expected item falls due. The monitor samples on the falling edge and pops an item only when the cycle count equals its due cycle. In every other cycle it requires all outputs to be idle, so a result that arrives early, late or twice is reported as a failure. Strobes on consecutive cycles queue two items with consecutive due cycles.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  // Bits that take part in the compare for a given frame format
  function automatic logic [ID_W-1:0] fmt_scope(input logic ide);
    logic [ID_W-1:0] s;
    s = '0;
    for (int i = ID_W - STD_W; i < ID_W; i++) s[i] = 1'b1;
    return ide ? '1 : s;
  endfunction

  // One buffer's accept decision
  function automatic logic id_accept(
    input logic [ID_W-1:0] fid,
    input logic            fide,
    input logic [ID_W-1:0] bid,
    input logic            bide,
    input logic [ID_W-1:0] msk
  );
    logic [ID_W-1:0] diff;
    diff = (fid ^ bid) & msk & fmt_scope(fide);
    return (fide == bide) && (diff == '0);
  endfunction
endpackage

// File: rtl/af_match_cell.sv
module af_match_cell
  import can_af_pkg::*;
#(
  parameter bit USE_SEP = 1'b0
) (
  input  logic [ID_W-1:0] frm_id,
  input  logic            frm_ide,
  input  logic            cfg_en,
  input  logic            cfg_rx,
  input  logic            cfg_ide,
  input  logic [ID_W-1:0] cfg_id,
  input  logic [ID_W-1:0] glob_mask,
  input  logic [ID_W-1:0] sep_mask,
  output logic            hit
);
  logic [ID_W-1:0] eff_mask;

  generate
    if (USE_SEP) begin : g_sep
      assign eff_mask = sep_mask;
    end else begin : g_glob
      assign eff_mask = glob_mask;
    end
  endgenerate

  assign hit = cfg_en && cfg_rx && id_accept(frm_id, frm_ide, cfg_id, cfg_ide, eff_mask);
endmodule

// File: rtl/af_first_pick.sv
module af_first_pick #(
  parameter int N   = 15,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   hit_vec,
  output logic [N-1:0]   win_oh,
  output logic [IDW-1:0] win_idx,
  output logic           any_hit
);
  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        win_oh     = '0;
        win_oh[i]  = 1'b1;
        win_idx    = IDW'(i);
      end
    end
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/af_result_reg.sv
module af_result_reg #(
  parameter int N   = 15,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe,
  input  logic           any_hit,
  input  logic [N-1:0]   win_oh,
  input  logic [IDW-1:0] win_idx,
  input  logic           rtr_in,
  output logic           go,
  output logic           miss,
  output logic [N-1:0]   oh,
  output logic [IDW-1:0] idx,
  output logic           rtr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go   <= 1'b0;
      miss <= 1'b0;
      oh   <= '0;
      idx  <= '0;
      rtr  <= 1'b0;
    end else if (strobe) begin
      go   <= any_hit;
      miss <= !any_hit;
      oh   <= any_hit ? win_oh : '0;
      idx  <= any_hit ? win_idx : '0;
      rtr  <= any_hit && rtr_in;
    end else begin
      go   <= 1'b0;
      miss <= 1'b0;
      oh   <= '0;
      idx  <= '0;
      rtr  <= 1'b0;
    end
  end

  // R9
  go_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && miss));

  // R11
  result_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (go ^ miss));

  // R11
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (!go && !miss && oh == '0));

  // R2
  onehot_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ($onehot0(oh) && oh == (N'(1) << idx)));

  // R10
  rtr_with_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtr |-> go);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_af_pkg::*;
#(
  parameter int NUM_BUF = 15,
  parameter int SEP_IDX = 14,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_valid,
  input  logic [ID_W-1:0]         frm_id,
  input  logic                    frm_ide,
  input  logic                    frm_rtr,
  input  logic [NUM_BUF-1:0]      buf_en,
  input  logic [NUM_BUF-1:0]      buf_rx,
  input  logic [NUM_BUF-1:0]      buf_ide,
  input  logic [NUM_BUF*ID_W-1:0] buf_id_flat,
  input  logic [ID_W-1:0]         glob_mask,
  input  logic [ID_W-1:0]         sep_mask,
  output logic                    copy_go,
  output logic [NUM_BUF-1:0]      copy_oh,
  output logic [IDX_W-1:0]        copy_idx,
  output logic                    copy_rtr,
  output logic                    no_match
);
  // Named internal events for the assertions
  logic [NUM_BUF-1:0] hit_vec;
  logic [NUM_BUF-1:0] win_oh;
  logic [IDX_W-1:0]   win_idx;
  logic               any_hit;
  logic [NUM_BUF-1:0] eligible;

  assign eligible = buf_en & buf_rx;

  generate
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_cell
      af_match_cell #(.USE_SEP(b == SEP_IDX)) u_cell (
        .frm_id    (frm_id),
        .frm_ide   (frm_ide),
        .cfg_en    (buf_en[b]),
        .cfg_rx    (buf_rx[b]),
        .cfg_ide   (buf_ide[b]),
        .cfg_id    (buf_id_flat[b*ID_W +: ID_W]),
        .glob_mask (glob_mask),
        .sep_mask  (sep_mask),
        .hit       (hit_vec[b])
      );
    end
  endgenerate

  af_first_pick #(.N(NUM_BUF), .IDW(IDX_W)) u_pick (
    .hit_vec (hit_vec),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .any_hit (any_hit)
  );

  af_result_reg #(.N(NUM_BUF), .IDW(IDX_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (frm_valid),
    .any_hit (any_hit),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .rtr_in  (frm_rtr),
    .go      (copy_go),
    .miss    (no_match),
    .oh      (copy_oh),
    .idx     (copy_idx),
    .rtr     (copy_rtr)
  );

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (((win_oh & hit_vec) == win_oh) && (((win_oh - 1'b1) & hit_vec) == '0)));

  // R6
  rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |-> ((copy_oh & $past(eligible)) == copy_oh));

  // R9
  miss_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && hit_vec == '0) |=> (no_match && copy_oh == '0));

  // R5
  ide_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |-> ((copy_oh & ($past(frm_ide) ? $past(buf_ide) : ~$past(buf_ide))) == copy_oh));
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
  localparam int NB = 15;
  localparam int IW = 29;
  localparam int SEP = 14;
  localparam logic [IW-1:0] STD_SC = 29'h1FFC0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic [IW-1:0] frm_id = '0;
  logic frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [NB-1:0] buf_en = '0, buf_rx = '0, buf_ide = '0;
  logic [IW-1:0] bid [NB];
  logic [NB*IW-1:0] buf_id_flat;
  logic [IW-1:0] glob_mask = '1, sep_mask = '1;
  logic copy_go, copy_rtr, no_match;
  logic [NB-1:0] copy_oh;
  logic [3:0] copy_idx;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NB; g++) begin : g_pack
    assign buf_id_flat[g*IW +: IW] = bid[g];
  end

  can_accept_filter dut_i (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_ide(frm_ide), .frm_rtr(frm_rtr), .buf_en(buf_en), .buf_rx(buf_rx),
    .buf_ide(buf_ide), .buf_id_flat(buf_id_flat), .glob_mask(glob_mask),
    .sep_mask(sep_mask), .copy_go(copy_go), .copy_oh(copy_oh),
    .copy_idx(copy_idx), .copy_rtr(copy_rtr), .no_match(no_match)
  );

  typedef struct {
    int    due;
    int    idx;
    logic  rtr;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Independent model: lowest eligible buffer whose masked id agrees, or -1
  function automatic int model_pick(logic [IW-1:0] id, logic ide);
    for (int b = 0; b < NB; b++) begin
      logic [IW-1:0] m;
      if (!(buf_en[b] && buf_rx[b]) || buf_ide[b] != ide) continue;
      m = (b == SEP) ? sep_mask : glob_mask;
      if (!ide) m = m & STD_SC;
      if (((id ^ bid[b]) & m) == 0) return b;
    end
    return -1;
  endfunction

  task automatic send(logic [IW-1:0] id, logic ide, logic rtr, string tag);
    exp_t e;
    @(negedge clk);
    frm_valid = 1'b1;
    frm_id = id;
    frm_ide = ide;
    frm_rtr = rtr;
    e.due = cyc + 1;
    e.idx = model_pick(id, ide);
    e.rtr = rtr;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frm_valid = 1'b0;
    end
  endtask

  task automatic set_buf(int b, logic en, logic rx, logic ide, logic [IW-1:0] id);
    buf_en[b] = en;
    buf_rx[b] = rx;
    buf_ide[b] = ide;
    bid[b] = id;
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        logic ok;
        e = exp_q.pop_front();
        n_chk++;
        if (e.idx < 0)
          ok = no_match && !copy_go && copy_oh == '0 && !copy_rtr;
        else
          ok = copy_go && !no_match && copy_idx == 4'(e.idx) &&
               copy_oh == (NB'(1) << e.idx) && copy_rtr == e.rtr;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: go=%0b miss=%0b idx=%0d oh=%h rtr=%0b expected idx=%0d rtr=%0b",
                   e.tag, copy_go, no_match, copy_idx, copy_oh, copy_rtr, e.idx, e.rtr);
        end
      end else if (rst_n) begin
        n_chk++;
        if (copy_go || no_match || copy_oh != '0 || copy_rtr) begin
          n_fail++;
          $display("FAIL R11 idle: go=%0b miss=%0b oh=%h rtr=%0b expected all 0",
                   copy_go, no_match, copy_oh, copy_rtr);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) bid[b] = '0;
    frm_valid = 1'b1;  // strobe during reset must be ignored
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    n_chk++;
    if (copy_go || no_match || copy_oh != '0 || copy_idx != '0 || copy_rtr) begin
      n_fail++;
      $display("FAIL R1: go=%0b miss=%0b oh=%h idx=%0d rtr=%0b expected all 0",
               copy_go, no_match, copy_oh, copy_idx, copy_rtr);
    end
    frm_valid = 1'b0;
    rst_n = 1'b1;
    idle(2);

    // R2: exact extended match, full mask
    set_buf(3, 1, 1, 1, 29'h1ABCDE12);
    send(29'h1ABCDE12, 1, 0, "R2 exact ext");
    idle(2);
    // R9: one bit off
    send(29'h1ABCDE13, 1, 0, "R9 no match");
    idle(2);
    // R3: group via cleared mask bits
    glob_mask = 29'h1FFFFFF0;
    send(29'h1ABCDE1F, 1, 1, "R3 group R10 rtr");
    idle(1);
    send(29'h1ABCDE2F, 1, 0, "R3 compared bit differs");
    idle(2);
    glob_mask = '1;
    // R4: standard frame, low bits ignored
    set_buf(5, 1, 1, 0, {11'h123, 18'h2AAAA});
    send({11'h123, 18'h15555}, 0, 0, "R4 std top bits");
    idle(1);
    send({11'h122, 18'h2AAAA}, 0, 0, "R4 std id differs");
    idle(2);
    // R5: same bits, extended format, does not hit std buffer
    send({11'h123, 18'h2AAAA}, 1, 0, "R5 ide mismatch");
    idle(2);
    // R6: tx and disabled buffers with same id are skipped
    set_buf(1, 1, 0, 1, 29'h1ABCDE12);
    set_buf(2, 0, 1, 1, 29'h1ABCDE12);
    send(29'h1ABCDE12, 1, 1, "R6 tx/disabled skipped");
    idle(2);
    // R7: lowest index wins, back-to-back strobes (R11)
    set_buf(7, 1, 1, 1, 29'h00000055);
    set_buf(9, 1, 1, 1, 29'h00000055);
    send(29'h00000055, 1, 0, "R7 lowest wins");
    send(29'h1ABCDE12, 1, 0, "R11 back-to-back");
    idle(2);
    set_buf(2, 1, 1, 1, 29'h1ABCDE12);
    send(29'h1ABCDE12, 1, 0, "R7 newly enabled lower");
    idle(2);
    // R8: dedicated buffer uses its own mask
    set_buf(SEP, 1, 1, 1, 29'h1F000000);
    sep_mask = 29'h1F000000;
    send(29'h1F00ABCD, 1, 1, "R8 sep mask catch");
    idle(2);
    sep_mask = '1;
    set_buf(SEP, 1, 1, 1, 29'h00000100);
    glob_mask = 29'h1FFFFF00;
    send(29'h00000101, 1, 0, "R8 global mask not applied");
    idle(2);
    glob_mask = '1;
    set_buf(SEP, 1, 1, 0, {11'h7F0, 18'h0});
    sep_mask = {11'h7F0, 18'h3FFFF};
    send({11'h7F5, 18'h12345}, 0, 1, "R8 sep std");
    idle(3);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule